// File: doc/BRIEF.md
# External interrupt pending register

This block holds the pending external interrupt requests of one processor. Any master on the system bus posts a request by writing a single 32-bit word. The block does not store the word. It turns the word into one pending bit, numbered from the most significant end: the bit index is the complement of the low data bits, limited to the current register width. A local timer alarm posts request number 0 in the same way. Local software removes requests through its own clear port, which works as write-one-to-clear. The bus can also read the whole pending register back.

The register is 32 bits wide by default. It switches to 64 bits at run time when the processor is built wide-capable and the default-wide control input is high. A level interrupt line is high while any bit is pending, whatever the mask. When the processor polls at an instruction boundary, the block decides what is taken. A held non-maskable request goes first and selects the transfer-of-control vector. Otherwise an external interrupt is taken only when the global enable is set and the pending bits meet the mask. The bus read response is a one-cycle valid pulse with no ready. The reader must accept it in the cycle it appears, and there is no back-pressure anywhere in the block.

Top module: `ext_irq_pending`

## Requirements
- R1: In 32-bit mode, a bus write of size code 2 (4 bytes) with data d sets pending bit (31 - (d mod 32)). Data 0 sets bit 31 and data 32 also sets bit 31.
- R2: When WIDE_CAPABLE is 1 and wide_default is high, a posted data value d sets bit (63 - (d mod 64)). When wide_default is low, the 32-bit rule of R1 applies.
- R3: A bus write whose size code is not 2 (codes 0, 1, 3 for 1, 2, 8 bytes) leaves the pending register unchanged.
- R4: A bus read with size code 2 gives rd_valid high for exactly one cycle, one clock after the request. bus_rdata then holds the pending register as it stood in the request cycle.
- R5: A clear-port write removes every pending bit that is 1 in sw_clr_mask and keeps every bit that is 0 in it.
- R6: A timer_alarm pulse sets the most significant bit of the current width: bit 31 in 32-bit mode, bit 63 in 64-bit mode. It can combine with a bus post in the same cycle.
- R7: irq_line is high exactly when any pending bit is set, whatever the value of irq_mask.
- R8: With no non-maskable request held, take_valid is high only while core_poll is high, glb_ie is high and the AND of pending and irq_mask is nonzero. take_vec is then VEC_EXT (default 4). Taking the interrupt does not clear pending bits.
- R9: A nmi_req pulse is held from the next cycle on. While it is held, core_poll gives take_valid with take_vec = VEC_TOC (default 31), ahead of any external interrupt and whatever glb_ie is. Taking it releases the hold on the next cycle.
- R10: When a post and a clear hit the same bit in the same cycle, the bit ends up set.
- R11: A synchronous active-high rst clears every pending bit and the held non-maskable request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write (post), 0 = read |
| bus_size | input | 2 | Transfer size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes |
| bus_wdata | input | 32 | Posted data word |
| bus_rdata | output | 64 | Read response: pending register |
| rd_valid | output | 1 | Read response valid, one-cycle pulse |
| sw_clr_valid | input | 1 | Clear-port write strobe |
| sw_clr_mask | input | 64 | Bits to clear |
| timer_alarm | input | 1 | Timer event, posts request 0 |
| wide_default | input | 1 | Selects 64-bit width when wide-capable |
| irq_mask | input | 64 | External interrupt enable mask |
| glb_ie | input | 1 | Global interrupt enable |
| nmi_req | input | 1 | Non-maskable request pulse |
| core_poll | input | 1 | Processor samples interrupts this cycle |
| irq_line | output | 1 | Level line, any bit pending |
| take_valid | output | 1 | Interrupt taken this cycle |
| take_vec | output | 6 | Vector code of the taken interrupt |

## Verification
The assertions check on every cycle that a same-cycle post beats a clear, and that a clear removes its masked bits. They also check that posts with a wrong size leave the register untouched, that an external take always has enable, mask and pending behind it, and that a polled non-maskable request is taken with the transfer-of-control code and then released. The bus bit numbering needs the bench's sweeps to show it: every data value in both widths, with bus reads checked against arithmetic. The same holds for the timer bit in each mode, the read-response timing, reset in mid-run, and the way the interrupt line ignores the mask.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  // Bus transfer size codes (log2 of bytes)
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } bus_size_e;
endpackage

// File: rtl/ext_irq_post_decode.sv
module ext_irq_post_decode #(
  parameter int REG_W        = 64,
  parameter int NARROW_W     = 32,
  parameter int WORD_W       = 32,
  parameter int WIDE_CAPABLE = 1
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              timer_alarm,
  input  logic              wide_default,
  output logic [REG_W-1:0]  set_vec
);
  import ext_irq_pkg::*;

  localparam int   IDX_W = $clog2(REG_W);
  localparam logic CAP   = (WIDE_CAPABLE != 0);

  logic             eff_wide;
  logic [IDX_W-1:0] idx_mask;
  logic [IDX_W-1:0] bus_idx;
  logic             post_ok;
  logic             unused_hi;

  assign eff_wide  = CAP & wide_default;
  assign idx_mask  = eff_wide ? IDX_W'(REG_W - 1) : IDX_W'(NARROW_W - 1);
  // complemented low bits select the bit, counting from the top
  assign bus_idx   = ~bus_wdata[IDX_W-1:0] & idx_mask;
  assign post_ok   = bus_valid & bus_write & (bus_size == SZ_WORD);
  assign unused_hi = ^bus_wdata[WORD_W-1:IDX_W];

  // timer event equals a post of data 0: index equals the width mask
  for (genvar i = 0; i < REG_W; i++) begin : g_set
    assign set_vec[i] = (post_ok && (bus_idx == IDX_W'(i))) ||
                        (timer_alarm && (idx_mask == IDX_W'(i)));
  end
endmodule

// File: rtl/ext_irq_pend_reg.sv
module ext_irq_pend_reg #(
  parameter int REG_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] set_vec,
  input  logic             clr_valid,
  input  logic [REG_W-1:0] clr_mask,
  input  logic             rd_req,
  output logic [REG_W-1:0] pend_q,
  output logic [REG_W-1:0] rdata,
  output logic             rd_valid
);
  logic [REG_W-1:0] clr_eff;
  logic [REG_W-1:0] pend_d;

  assign clr_eff = clr_valid ? clr_mask : '0;
  // set applied after clear: a set wins on a collision
  assign pend_d  = (pend_q & ~clr_eff) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      rd_valid <= rd_req;
      if (rd_req) rdata <= pend_q;
    end
  end
endmodule

// File: rtl/ext_irq_arbiter.sv
module ext_irq_arbiter #(
  parameter int REG_W   = 64,
  parameter int VEC_W   = 6,
  parameter int VEC_EXT = 4,
  parameter int VEC_TOC = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] pend,
  input  logic [REG_W-1:0] irq_mask,
  input  logic             glb_ie,
  input  logic             nmi_req,
  input  logic             core_poll,
  output logic             irq_line,
  output logic             take_valid,
  output logic [VEC_W-1:0] take_vec,
  output logic             nmi_held
);
  logic ext_ok;
  logic nmi_take;

  assign irq_line   = |pend;
  assign ext_ok     = irq_line & glb_ie & (|(pend & irq_mask));
  assign nmi_take   = core_poll & nmi_held;
  assign take_valid = nmi_take | (core_poll & ext_ok);
  assign take_vec   = nmi_held ? VEC_W'(VEC_TOC) : VEC_W'(VEC_EXT);

  always_ff @(posedge clk) begin
    if (rst) nmi_held <= 1'b0;
    else     nmi_held <= nmi_req | (nmi_held & ~nmi_take);
  end
endmodule

// File: rtl/ext_irq_pending.sv
module ext_irq_pending #(
  parameter int REG_W        = 64,
  parameter int NARROW_W     = 32,
  parameter int WORD_W       = 32,
  parameter int WIDE_CAPABLE = 1,
  parameter int VEC_W        = 6,
  parameter int VEC_EXT      = 4,
  parameter int VEC_TOC      = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              rd_valid,
  input  logic              sw_clr_valid,
  input  logic [REG_W-1:0]  sw_clr_mask,
  input  logic              timer_alarm,
  input  logic              wide_default,
  input  logic [REG_W-1:0]  irq_mask,
  input  logic              glb_ie,
  input  logic              nmi_req,
  input  logic              core_poll,
  output logic              irq_line,
  output logic              take_valid,
  output logic [VEC_W-1:0]  take_vec
);
  import ext_irq_pkg::*;

  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] pend_q;
  logic             rd_req;
  logic             nmi_held;

  assign rd_req = bus_valid & ~bus_write & (bus_size == SZ_WORD);

  ext_irq_post_decode #(
    .REG_W(REG_W), .NARROW_W(NARROW_W), .WORD_W(WORD_W),
    .WIDE_CAPABLE(WIDE_CAPABLE)
  ) u_decode (
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_size    (bus_size),
    .bus_wdata   (bus_wdata),
    .timer_alarm (timer_alarm),
    .wide_default(wide_default),
    .set_vec     (set_vec)
  );

  ext_irq_pend_reg #(.REG_W(REG_W)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (set_vec),
    .clr_valid(sw_clr_valid),
    .clr_mask (sw_clr_mask),
    .rd_req   (rd_req),
    .pend_q   (pend_q),
    .rdata    (bus_rdata),
    .rd_valid (rd_valid)
  );

  ext_irq_arbiter #(
    .REG_W(REG_W), .VEC_W(VEC_W), .VEC_EXT(VEC_EXT), .VEC_TOC(VEC_TOC)
  ) u_arb (
    .clk       (clk),
    .rst       (rst),
    .pend      (pend_q),
    .irq_mask  (irq_mask),
    .glb_ie    (glb_ie),
    .nmi_req   (nmi_req),
    .core_poll (core_poll),
    .irq_line  (irq_line),
    .take_valid(take_valid),
    .take_vec  (take_vec),
    .nmi_held  (nmi_held)
  );
endmodule

// File: rtl/ext_irq_pending_chk.sv
module ext_irq_pending_chk #(
  parameter int REG_W   = 64,
  parameter int VEC_W   = 6,
  parameter int VEC_EXT = 4,
  parameter int VEC_TOC = 31
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [1:0]       bus_size,
  input logic             sw_clr_valid,
  input logic [REG_W-1:0] sw_clr_mask,
  input logic             timer_alarm,
  input logic [REG_W-1:0] irq_mask,
  input logic             glb_ie,
  input logic             nmi_req,
  input logic             irq_line,
  input logic             take_valid,
  input logic [VEC_W-1:0] take_vec,
  input logic [REG_W-1:0] pend,
  input logic [REG_W-1:0] set_vec,
  input logic             nmi_held
);
  assert_bad_size_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_size != 2'd2 && !timer_alarm && !sw_clr_valid)
      |=> $stable(pend));

  assert_clear_removes_R5: assert property (@(posedge clk) disable iff (rst)
    sw_clr_valid |=> ((pend & $past(sw_clr_mask) & ~$past(set_vec)) == '0));

  assert_ext_take_gated_R8: assert property (@(posedge clk) disable iff (rst)
    (take_valid && !nmi_held) |->
      (take_vec == VEC_W'(VEC_EXT) && glb_ie && irq_line && (|(pend & irq_mask))));

  assert_nmi_vector_R9: assert property (@(posedge clk) disable iff (rst)
    (take_valid && nmi_held) |-> (take_vec == VEC_W'(VEC_TOC)));

  assert_nmi_release_R9: assert property (@(posedge clk) disable iff (rst)
    (take_valid && take_vec == VEC_W'(VEC_TOC) && !nmi_req) |=> !nmi_held);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((pend & $past(set_vec)) == $past(set_vec)));

  assert_reset_clears_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pend == '0 && !nmi_held));
endmodule

bind ext_irq_pending ext_irq_pending_chk #(
  .REG_W(REG_W), .VEC_W(VEC_W), .VEC_EXT(VEC_EXT), .VEC_TOC(VEC_TOC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_valid   (bus_valid),
  .bus_write   (bus_write),
  .bus_size    (bus_size),
  .sw_clr_valid(sw_clr_valid),
  .sw_clr_mask (sw_clr_mask),
  .timer_alarm (timer_alarm),
  .irq_mask    (irq_mask),
  .glb_ie      (glb_ie),
  .nmi_req     (nmi_req),
  .irq_line    (irq_line),
  .take_valid  (take_valid),
  .take_vec    (take_vec),
  .pend        (pend_q),
  .set_vec     (set_vec),
  .nmi_held    (nmi_held)
);

// File: tb/ext_irq_pending_tb.sv
module ext_irq_pending_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 0, bus_write = 0;
  logic [1:0]  bus_size = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        rd_valid;
  logic        sw_clr_valid = 0;
  logic [63:0] sw_clr_mask = '0;
  logic        timer_alarm = 0, wide_default = 0;
  logic [63:0] irq_mask = '0;
  logic        glb_ie = 0, nmi_req = 0, core_poll = 0;
  logic        irq_line, take_valid;
  logic [5:0]  take_vec;

  int n_chk = 0;
  int n_err = 0;
  logic [63:0] rv;
  logic        rvld;

  always #2.5 clk = ~clk;

  ext_irq_pending u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rd_valid(rd_valid), .sw_clr_valid(sw_clr_valid), .sw_clr_mask(sw_clr_mask),
    .timer_alarm(timer_alarm), .wide_default(wide_default), .irq_mask(irq_mask),
    .glb_ie(glb_ie), .nmi_req(nmi_req), .core_poll(core_poll),
    .irq_line(irq_line), .take_valid(take_valid), .take_vec(take_vec)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_bit(input int d, input bit wide);
    int idx;
    idx = wide ? 63 - (d % 64) : 31 - (d % 32);
    return 64'd1 << idx;
  endfunction

  task automatic post(input logic [31:0] d, input logic [1:0] sz);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; bus_size = 2'd2;
  endtask

  task automatic clr(input logic [63:0] m);
    @(negedge clk);
    sw_clr_valid = 1; sw_clr_mask = m;
    @(negedge clk);
    sw_clr_valid = 0;
  endtask

  task automatic rd();
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_size = 2'd2;
    @(negedge clk);
    bus_valid = 0;
    rv = bus_rdata; rvld = rd_valid;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R11: reset state
    rd();
    check("R11 rdata after reset", rv, 64'd0);
    check("R11 irq_line after reset", {63'd0, irq_line}, 64'd0);
    core_poll = 1; glb_ie = 1; irq_mask = '1;
    #1 check("R11 no take after reset", {63'd0, take_valid}, 64'd0);
    core_poll = 0; glb_ie = 0; irq_mask = '0;

    // R1: narrow sweep, including masking of high data bits
    wide_default = 0;
    for (int d = 0; d < 64; d++) begin
      clr('1);
      post(32'(d), 2'd2);
      rd();
      check("R1 narrow index", rv, exp_bit(d, 0));
    end
    // R2: wide sweep and masking above 63
    wide_default = 1;
    for (int d = 0; d < 70; d++) begin
      clr('1);
      post(32'(d), 2'd2);
      rd();
      check("R2 wide index", rv, exp_bit(d, 1));
    end
    wide_default = 0;

    // R4: read response timing
    clr('1);
    post(32'd0, 2'd2);
    rd();
    check("R4 rd_valid pulse", {63'd0, rvld}, 64'd1);
    check("R4 rdata", rv, 64'h8000_0000);
    @(negedge clk);
    check("R4 rd_valid drops", {63'd0, rd_valid}, 64'd0);

    // R3: wrong sizes ignored
    clr('1);
    for (int s = 0; s < 4; s++) begin
      if (s != 2) post(32'd0, 2'(s));
    end
    rd();
    check("R3 bad size ignored", rv, 64'd0);
    check("R3 line stays low", {63'd0, irq_line}, 64'd0);

    // R5: clear selected bits
    post(32'd1, 2'd2); post(32'd2, 2'd2); post(32'd3, 2'd2);
    clr(64'h2000_0000);
    rd();
    check("R5 w1c", rv, 64'h5000_0000);

    // R10: set and clear same bit, same cycle
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_wdata = 32'd5;
    sw_clr_valid = 1; sw_clr_mask = 64'h4400_0000;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; sw_clr_valid = 0;
    rd();
    check("R10 set wins", rv, 64'h1400_0000);

    // R6: timer in each mode, with a simultaneous post
    clr('1);
    @(negedge clk); timer_alarm = 1; @(negedge clk); timer_alarm = 0;
    rd();
    check("R6 timer narrow", rv, 64'h8000_0000);
    clr('1);
    wide_default = 1;
    @(negedge clk);
    timer_alarm = 1; bus_valid = 1; bus_write = 1; bus_wdata = 32'd1;
    @(negedge clk);
    timer_alarm = 0; bus_valid = 0; bus_write = 0;
    rd();
    check("R6 timer wide plus post", rv, 64'hC000_0000_0000_0000);
    wide_default = 0;

    // R7: line ignores mask
    clr('1);
    post(32'd31, 2'd2);
    irq_mask = '0;
    #1 check("R7 line with zero mask", {63'd0, irq_line}, 64'd1);
    clr(64'd1);
    check("R7 line low when empty", {63'd0, irq_line}, 64'd0);

    // R8: acceptance conditions (pending bit 31)
    post(32'd0, 2'd2);
    core_poll = 1; glb_ie = 1; irq_mask = 64'h8000_0000;
    #1 check("R8 take", {63'd0, take_valid}, 64'd1);
    check("R8 vector ext", 64'(take_vec), 64'd4);
    glb_ie = 0;
    #1 check("R8 no take ie off", {63'd0, take_valid}, 64'd0);
    glb_ie = 1; irq_mask = 64'h4000_0000;
    #1 check("R8 no take masked", {63'd0, take_valid}, 64'd0);
    irq_mask = 64'h8000_0000; core_poll = 0;
    #1 check("R8 no take no poll", {63'd0, take_valid}, 64'd0);
    @(negedge clk);
    core_poll = 1;
    @(negedge clk);
    core_poll = 0;
    rd();
    check("R8 take keeps pending", rv, 64'h8000_0000);

    // R9: non-maskable priority and release
    glb_ie = 0;
    @(negedge clk); nmi_req = 1; @(negedge clk); nmi_req = 0;
    #1 check("R9 held not taken without poll", {63'd0, take_valid}, 64'd0);
    core_poll = 1;
    #1 check("R9 nmi take ie off", {63'd0, take_valid}, 64'd1);
    check("R9 toc vector", 64'(take_vec), 64'd31);
    glb_ie = 1;
    #1 check("R9 nmi beats ext", 64'(take_vec), 64'd31);
    @(negedge clk);
    #1 check("R9 released, ext next", 64'(take_vec), 64'd4);
    glb_ie = 0;
    #1 check("R9 no second nmi take", {63'd0, take_valid}, 64'd0);
    core_poll = 0;

    // R11: reset in mid-run clears pending and held request
    @(negedge clk); nmi_req = 1; @(negedge clk); nmi_req = 0;
    rst = 1; @(negedge clk); rst = 0;
    core_poll = 1;
    #1 check("R11 nmi cleared by reset", {63'd0, take_valid}, 64'd0);
    core_poll = 0;
    rd();
    check("R11 pending cleared by reset", rv, 64'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule